// File: doc/BRIEF.md
# Transmit Queue Drain Sequencer

This block takes a request to halt one transmit queue and walks that queue through a controlled shutdown. It ends only when the queue has emptied or every permitted wait has run out. The block raises the queue's early-termination control first, which lets the queue flush. It then writes the queue's disable bit. After that it watches two things for the selected queue: the queue's running status and its count of frames still waiting. Polling is paced by a one-microsecond tick input, and every wait has an upper bound.

Frames may still be waiting after the normal wait. When the quiet fallback is allowed, the block then schedules a quiet interval on the medium and forces the channel-idle indication high. It holds both for a fixed time, lifts the quiet interval, and checks the frame count again for a shorter window. The sequence always finishes the same way. Early termination is cleared, the whole disable register is written to zero, and a one-cycle completion pulse carries a result code.

Only one sequence runs at a time. The block raises a busy output while it works, and it ignores stop requests that arrive during that time.

Top module: `txq_drain_seq`

## Requirements
- R1: While reset is held and after it is released, busy, done, ena_warn, quiet_en and chan_idle_force are 0, and q_txd and q_early_term are all zero.
- R2: A stop request made while idle is rejected when it names a queue whose q_active bit is 0 or whose index is NUM_Q or higher. On the next cycle done pulses with res_code 2'b01, busy stays 0, no control output changes, and ena_warn keeps its value.
- R3: An accepted request sets busy and the early-termination bit of the named queue on the next cycle, while q_txd is still all zero. On the cycle after that, q_txd has only that queue's bit set. Bit i of q_early_term and of q_txd belongs to queue i.
- R4: After the disable, the selected queue's q_txe_sts bit is sampled up to ENA_TRIES times, POLL_GAP_US ticks apart. The first sample that reads 0 moves the sequence on without raising ena_warn.
- R5: If every enable-status sample reads 1, ena_warn is set and the sequence continues with the pending poll. ena_warn then holds its value until the next accepted request clears it.
- R6: The selected queue's pending count (field i of q_pend_cnt at bits i*CNT_W upward) is sampled up to PEND_TRIES times, POLL_GAP_US ticks apart. A zero sample ends the drain with success and no quiet step.
- R7: When the count is still non-zero after those samples and quiet_allow is 1, the block sets quiet_en, quiet_period = QUIET_PERIOD, quiet_dur = QUIET_DURATION, quiet_next = tsf_now >> 10 and chan_idle_force = 1. It drops quiet_en after QUIET_WAIT_US ticks.
- R8: After the quiet interval, the pending count is sampled up to QUIET_TRIES more times, and chan_idle_force is released before done pulses.
- R9: Every sequence ends with a single done pulse. In that cycle busy is 0, and q_early_term and q_txd are all zero, whatever the result.
- R10: The result at done is 2'b00 when the last pending sample read zero and 2'b10 when frames were still pending.
- R11: With quiet_allow at 0, a pending timeout skips the quiet step entirely (quiet_en and chan_idle_force never rise) and ends with res_code 2'b10.
- R12: A stop request that arrives while busy is ignored. It neither ends, restarts nor redirects the running sequence, and it produces no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond, paces all waits |
| stop_req | input | 1 | Request to drain the queue named by stop_qid |
| stop_qid | input | QW | Index of the queue to drain |
| q_active | input | NUM_Q | Per-queue flag, 1 when the queue is configured |
| quiet_allow | input | 1 | Enables the forced-quiet fallback |
| tsf_now | input | TSF_W | Current timer value |
| q_txe_sts | input | NUM_Q | Per-queue running status |
| q_pend_cnt | input | NUM_Q*CNT_W | Per-queue pending-frame counts, packed |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| res_code | output | 2 | 00 success, 01 invalid queue, 10 frames still pending |
| ena_warn | output | 1 | Sticky: running status never cleared in the last sequence |
| q_early_term | output | NUM_Q | Per-queue early-termination control |
| q_txd | output | NUM_Q | Per-queue disable register |
| quiet_en | output | 1 | Quiet interval armed |
| quiet_period | output | QPER_W | Quiet repeat period |
| quiet_dur | output | QDUR_W | Quiet interval length |
| quiet_next | output | TSF_W | Timer value at which the quiet interval starts |
| chan_idle_force | output | 1 | Forces the channel-idle indication high |

## Verification
The drain is exercised with a queue that stops and empties quickly, and with a queue that stops late and empties late; these two separate correct queue selection from correct pacing of the polls. A queue whose running status never clears shows that the warning is raised without aborting the sequence, and the following clean run shows that the warning is cleared again. Queues whose frames never leave are run three ways: the quiet interval clears them, the quiet interval fails to clear them, and the fallback is disabled. Those three runs tell the escalation path apart from both outcomes of the plain timeout. Requests for an inactive queue, for an out-of-range index and during a running sequence confirm that rejection and ignoring leave the controls untouched.

// File: rtl/txq_drain_pkg.sv
package txq_drain_pkg;

    // Sequencer phases
    typedef enum logic [3:0] {
        S_IDLE,
        S_DISABLE,
        S_POLL_ENA,
        S_POLL_PEND,
        S_QUIET_ARM,
        S_QUIET_HOLD,
        S_QUIET_POLL,
        S_RELEASE,
        S_CLEANUP
    } drain_state_e;

    // Completion codes reported with done
    typedef enum logic [1:0] {
        RES_OK      = 2'b00,
        RES_INVALID = 2'b01,
        RES_BUSY    = 2'b10
    } drain_res_e;

    // Timer right-shift applied when scheduling the quiet interval
    localparam int QUIET_SHIFT = 10;

endpackage

// File: rtl/txq_status_sel.sv
// Picks one queue's status out of the per-queue vectors.
module txq_status_sel #(
    parameter int NUM_Q = 10,
    parameter int CNT_W = 8,
    parameter int QW    = $clog2(NUM_Q)
) (
    input  logic [QW-1:0]          sel,
    input  logic [NUM_Q-1:0]       active,
    input  logic [NUM_Q-1:0]       txe_sts,
    input  logic [NUM_Q*CNT_W-1:0] pend_flat,
    output logic                   sel_valid,
    output logic                   sel_txe,
    output logic                   sel_pend_nz
);

    logic [NUM_Q-1:0] hit;
    logic [NUM_Q-1:0] pend_nz;

    // One comparator per queue; an out-of-range index hits nothing
    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
        assign hit[i]     = (sel == QW'(i));
        assign pend_nz[i] = |pend_flat[i*CNT_W +: CNT_W];
    end

    assign sel_valid   = |(hit & active);
    assign sel_txe     = |(hit & txe_sts);
    assign sel_pend_nz = |(hit & pend_nz);

endmodule

// File: rtl/txq_tick_timer.sv
// Down-counter paced by the microsecond tick; expired while at zero.
module txq_tick_timer #(
    parameter int TMR_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             expired
);

    logic [TMR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (us_tick && (cnt_q != '0)) begin
            cnt_d = cnt_q - TMR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/txq_drain_seq.sv
// Transmit queue drain sequencer: early-terminate, disable, bounded polls,
// optional forced quiet fallback, unconditional cleanup.
module txq_drain_seq
    import txq_drain_pkg::*;
#(
    parameter int NUM_Q          = 10,
    parameter int QW             = $clog2(NUM_Q),
    parameter int CNT_W          = 8,
    parameter int TSF_W          = 32,
    parameter int QPER_W         = 16,
    parameter int QDUR_W         = 16,
    parameter int POLL_GAP_US    = 100,
    parameter int ENA_TRIES      = 1000,
    parameter int PEND_TRIES     = 1000,
    parameter int QUIET_TRIES    = 100,
    parameter int QUIET_WAIT_US  = 400,
    parameter int QUIET_PERIOD   = 100,
    parameter int QUIET_DURATION = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   us_tick,
    input  logic                   stop_req,
    input  logic [QW-1:0]          stop_qid,
    input  logic [NUM_Q-1:0]       q_active,
    input  logic                   quiet_allow,
    input  logic [TSF_W-1:0]       tsf_now,
    input  logic [NUM_Q-1:0]       q_txe_sts,
    input  logic [NUM_Q*CNT_W-1:0] q_pend_cnt,
    output logic                   busy,
    output logic                   done,
    output logic [1:0]             res_code,
    output logic                   ena_warn,
    output logic [NUM_Q-1:0]       q_early_term,
    output logic [NUM_Q-1:0]       q_txd,
    output logic                   quiet_en,
    output logic [QPER_W-1:0]      quiet_period,
    output logic [QDUR_W-1:0]      quiet_dur,
    output logic [TSF_W-1:0]       quiet_next,
    output logic                   chan_idle_force
);

    // Derived sizes
    localparam int MAX_TRY_A = (ENA_TRIES > PEND_TRIES) ? ENA_TRIES : PEND_TRIES;
    localparam int MAX_TRY   = (MAX_TRY_A > QUIET_TRIES) ? MAX_TRY_A : QUIET_TRIES;
    localparam int TRY_W     = $clog2(MAX_TRY + 1);
    localparam int MAX_WAIT  = (POLL_GAP_US > QUIET_WAIT_US) ? POLL_GAP_US : QUIET_WAIT_US;
    localparam int TMR_W     = $clog2(MAX_WAIT + 1);

    typedef struct packed {
        drain_state_e      st;
        logic [QW-1:0]     qid;
        logic [TRY_W-1:0]  tries;
        logic [NUM_Q-1:0]  early;
        logic [NUM_Q-1:0]  txd;
        logic              quiet_en;
        logic [QPER_W-1:0] qper;
        logic [QDUR_W-1:0] qdur;
        logic [TSF_W-1:0]  qnext;
        logic              idle_force;
        logic              warn;
        logic              pend_left;
        logic              done;
        drain_res_e        res;
    } ctl_t;

    ctl_t cs_q, cs_d;

    logic             sel_valid;
    logic             sel_txe;
    logic             sel_pend_nz;
    logic [QW-1:0]    sel_qid;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_exp;

    // While idle the incoming index is inspected, otherwise the latched one
    assign sel_qid = (cs_q.st == S_IDLE) ? stop_qid : cs_q.qid;

    txq_status_sel #(
        .NUM_Q (NUM_Q),
        .CNT_W (CNT_W),
        .QW    (QW)
    ) u_sel (
        .sel         (sel_qid),
        .active      (q_active),
        .txe_sts     (q_txe_sts),
        .pend_flat   (q_pend_cnt),
        .sel_valid   (sel_valid),
        .sel_txe     (sel_txe),
        .sel_pend_nz (sel_pend_nz)
    );

    txq_tick_timer #(
        .TMR_W (TMR_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .us_tick  (us_tick),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    always_comb begin
        cs_d      = cs_q;
        cs_d.done = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = TMR_W'(POLL_GAP_US);

        unique case (cs_q.st)
            S_IDLE: begin
                if (stop_req) begin
                    if (!sel_valid) begin
                        // Rejected: report at once, touch nothing
                        cs_d.done = 1'b1;
                        cs_d.res  = RES_INVALID;
                    end else begin
                        cs_d.qid             = stop_qid;
                        cs_d.early[stop_qid] = 1'b1;
                        cs_d.warn            = 1'b0;
                        cs_d.pend_left       = 1'b0;
                        cs_d.tries           = '0;
                        cs_d.st              = S_DISABLE;
                    end
                end
            end

            S_DISABLE: begin
                cs_d.txd[cs_q.qid] = 1'b1;
                cs_d.tries         = '0;
                cs_d.st            = S_POLL_ENA;
            end

            S_POLL_ENA: begin
                if (tmr_exp) begin
                    if (!sel_txe) begin
                        cs_d.tries = '0;
                        cs_d.st    = S_POLL_PEND;
                    end else if (cs_q.tries == TRY_W'(ENA_TRIES - 1)) begin
                        // Stop not confirmed: warn and carry on
                        cs_d.warn  = 1'b1;
                        cs_d.tries = '0;
                        cs_d.st    = S_POLL_PEND;
                    end else begin
                        cs_d.tries = cs_q.tries + TRY_W'(1);
                        tmr_load   = 1'b1;
                    end
                end
            end

            S_POLL_PEND: begin
                if (tmr_exp) begin
                    if (!sel_pend_nz) begin
                        cs_d.pend_left = 1'b0;
                        cs_d.st        = S_CLEANUP;
                    end else if (cs_q.tries == TRY_W'(PEND_TRIES - 1)) begin
                        cs_d.pend_left = 1'b1;
                        cs_d.tries     = '0;
                        cs_d.st        = quiet_allow ? S_QUIET_ARM : S_CLEANUP;
                    end else begin
                        cs_d.tries = cs_q.tries + TRY_W'(1);
                        tmr_load   = 1'b1;
                    end
                end
            end

            S_QUIET_ARM: begin
                cs_d.quiet_en   = 1'b1;
                cs_d.qper       = QPER_W'(QUIET_PERIOD);
                cs_d.qdur       = QDUR_W'(QUIET_DURATION);
                cs_d.qnext      = tsf_now >> QUIET_SHIFT;
                cs_d.idle_force = 1'b1;
                tmr_load        = 1'b1;
                tmr_val         = TMR_W'(QUIET_WAIT_US);
                cs_d.st         = S_QUIET_HOLD;
            end

            S_QUIET_HOLD: begin
                if (tmr_exp) begin
                    cs_d.quiet_en = 1'b0;
                    cs_d.tries    = '0;
                    cs_d.st       = S_QUIET_POLL;
                end
            end

            S_QUIET_POLL: begin
                if (tmr_exp) begin
                    if (!sel_pend_nz) begin
                        cs_d.pend_left = 1'b0;
                        cs_d.st        = S_RELEASE;
                    end else if (cs_q.tries == TRY_W'(QUIET_TRIES - 1)) begin
                        cs_d.pend_left = 1'b1;
                        cs_d.st        = S_RELEASE;
                    end else begin
                        cs_d.tries = cs_q.tries + TRY_W'(1);
                        tmr_load   = 1'b1;
                    end
                end
            end

            S_RELEASE: begin
                cs_d.idle_force = 1'b0;
                cs_d.st         = S_CLEANUP;
            end

            S_CLEANUP: begin
                // Always undone, whatever the drain outcome
                cs_d.early = '0;
                cs_d.txd   = '0;
                cs_d.done  = 1'b1;
                cs_d.res   = cs_q.pend_left ? RES_BUSY : RES_OK;
                cs_d.st    = S_IDLE;
            end

            default: cs_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '{st: S_IDLE, res: RES_OK, default: '0};
        end else begin
            cs_q <= cs_d;
        end
    end

    assign busy            = (cs_q.st != S_IDLE);
    assign done            = cs_q.done;
    assign res_code        = cs_q.res;
    assign ena_warn        = cs_q.warn;
    assign q_early_term    = cs_q.early;
    assign q_txd           = cs_q.txd;
    assign quiet_en        = cs_q.quiet_en;
    assign quiet_period    = cs_q.qper;
    assign quiet_dur       = cs_q.qdur;
    assign quiet_next      = cs_q.qnext;
    assign chan_idle_force = cs_q.idle_force;

endmodule

// File: rtl/txq_drain_seq_chk.sv
module txq_drain_seq_chk #(
    parameter int NUM_Q = 10,
    parameter int QW    = $clog2(NUM_Q)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_req,
    input logic [QW-1:0]    stop_qid,
    input logic [NUM_Q-1:0] q_active,
    input logic             busy,
    input logic             done,
    input logic [1:0]       res_code,
    input logic [NUM_Q-1:0] q_early_term,
    input logic [NUM_Q-1:0] q_txd,
    input logic             quiet_en,
    input logic             chan_idle_force
);

    logic req_ok;
    assign req_ok = (int'(stop_qid) < NUM_Q) && q_active[stop_qid];

    assert_idle_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (q_txd == '0 && q_early_term == '0 && !quiet_en && !chan_idle_force));

    assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_req && !req_ok) |=> (done && res_code == 2'b01 && !busy));

    assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_req && req_ok) |=>
            (busy && q_txd == '0 && q_early_term == (NUM_Q'(1) << $past(stop_qid))));

    assert_quiet_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_en |-> chan_idle_force);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_no_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    assert_one_disable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q_txd) <= 1);

    assert_res_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_code != 2'b11 && !busy));

endmodule

bind txq_drain_seq txq_drain_seq_chk #(
    .NUM_Q (NUM_Q),
    .QW    (QW)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .stop_req        (stop_req),
    .stop_qid        (stop_qid),
    .q_active        (q_active),
    .busy            (busy),
    .done            (done),
    .res_code        (res_code),
    .q_early_term    (q_early_term),
    .q_txd           (q_txd),
    .quiet_en        (quiet_en),
    .chan_idle_force (chan_idle_force)
);

// File: tb/txq_drain_seq_tb.sv
`timescale 1ns/1ps
module txq_drain_seq_tb;

    localparam int NQ    = 6;
    localparam int QW    = 3;
    localparam int CW    = 6;
    localparam int GAP   = 3;
    localparam int ETRY  = 5;
    localparam int PTRY  = 5;
    localparam int QTRY  = 4;
    localparam int QWAIT = 8;
    localparam int TW    = 32;
    localparam logic [1:0] R_OK  = 2'b00;
    localparam logic [1:0] R_INV = 2'b01;
    localparam logic [1:0] R_BSY = 2'b10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             us_tick = 1'b0;
    logic             stop_req = 1'b0;
    logic [QW-1:0]    stop_qid = '0;
    logic [NQ-1:0]    q_active = 6'b111101;
    logic             quiet_allow = 1'b0;
    logic [TW-1:0]    tsf_now = '0;
    logic [NQ-1:0]    q_txe_sts;
    logic [NQ*CW-1:0] q_pend_cnt;
    logic             busy, done, ena_warn, quiet_en, chan_idle_force;
    logic [1:0]       res_code;
    logic [NQ-1:0]    q_early_term, q_txd;
    logic [15:0]      quiet_period, quiet_dur;
    logic [TW-1:0]    quiet_next;

    always #2.5 clk = ~clk;
    always @(negedge clk) us_tick <= ~us_tick;

    txq_drain_seq #(
        .NUM_Q(NQ), .QW(QW), .CNT_W(CW), .TSF_W(TW), .QPER_W(16), .QDUR_W(16),
        .POLL_GAP_US(GAP), .ENA_TRIES(ETRY), .PEND_TRIES(PTRY),
        .QUIET_TRIES(QTRY), .QUIET_WAIT_US(QWAIT),
        .QUIET_PERIOD(100), .QUIET_DURATION(10)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .stop_req(stop_req),
        .stop_qid(stop_qid), .q_active(q_active), .quiet_allow(quiet_allow),
        .tsf_now(tsf_now), .q_txe_sts(q_txe_sts), .q_pend_cnt(q_pend_cnt),
        .busy(busy), .done(done), .res_code(res_code), .ena_warn(ena_warn),
        .q_early_term(q_early_term), .q_txd(q_txd), .quiet_en(quiet_en),
        .quiet_period(quiet_period), .quiet_dur(quiet_dur),
        .quiet_next(quiet_next), .chan_idle_force(chan_idle_force)
    );

    // Queue stub: the targeted queue stops and empties after configured delays
    int cfg_q = 0, cfg_txe_after = -1, cfg_pend_after = -1;
    bit cfg_quiet_fix = 1'b0;
    int since = 0, qcnt = 0;

    always @(posedge clk) begin
        if (!busy) begin
            since <= 0;
            qcnt  <= 0;
        end else begin
            since <= since + 1;
            if (chan_idle_force) qcnt <= qcnt + 1;
        end
    end

    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            q_txe_sts[i]         = 1'b1;
            q_pend_cnt[i*CW +: CW] = CW'(7);
            if (i == cfg_q) begin
                if (cfg_txe_after >= 0 && since >= cfg_txe_after) q_txe_sts[i] = 1'b0;
                if ((cfg_pend_after >= 0 && since >= cfg_pend_after) ||
                    (cfg_quiet_fix && qcnt >= 3))
                    q_pend_cnt[i*CW +: CW] = '0;
                else
                    q_pend_cnt[i*CW +: CW] = CW'(5);
            end
        end
    end

    // Scoreboard
    typedef struct {
        logic [1:0] res;
        bit         warn;
        bit         quiet;
        string      tag;
    } exp_t;
    exp_t sb[$];

    int n_checks = 0, n_err = 0, n_done = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp_v);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    // Monitor
    bit quiet_seen = 1'b0, quiet_was = 1'b0;
    int qticks = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (quiet_en && !quiet_was) begin
                quiet_seen = 1'b1;
                qticks     = 0;
                chk(quiet_period == 16'd100, "R7 quiet period", quiet_period, 100);
                chk(quiet_dur == 16'd10, "R7 quiet duration", quiet_dur, 10);
                chk(quiet_next == (tsf_now >> 10), "R7 quiet start", quiet_next, tsf_now >> 10);
                chk(chan_idle_force, "R7 idle forced", chan_idle_force, 1);
            end
            if (quiet_en && us_tick) qticks++;
            if (!quiet_en && quiet_was)
                chk(qticks >= QWAIT && qticks <= QWAIT + 1, "R7 quiet hold ticks", qticks, QWAIT);
            quiet_was = quiet_en;

            if (done) begin
                n_done++;
                if (sb.size() == 0) begin
                    chk(1'b0, "R12 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(res_code == e.res, {e.tag, " R10 result"}, res_code, e.res);
                    chk(ena_warn == e.warn, {e.tag, " R5 warn"}, ena_warn, e.warn);
                    chk(quiet_seen == e.quiet, {e.tag, " R11 quiet use"}, quiet_seen, e.quiet);
                    chk(q_txd == '0 && q_early_term == '0 && !busy, {e.tag, " R9 cleanup"},
                        {q_txd, q_early_term}, 0);
                    chk(!chan_idle_force, {e.tag, " R8 idle released"}, chan_idle_force, 0);
                end
                quiet_seen = 1'b0;
            end
        end
    end

    task automatic run_stop(input int q, input int txe_a, input int pend_a,
                            input bit qfix, input bit allow, input logic [1:0] eres,
                            input bit ewarn, input bit equiet, input bit poke,
                            input string tag);
        exp_t e;
        int d0;
        @(negedge clk);
        cfg_q = q; cfg_txe_after = txe_a; cfg_pend_after = pend_a;
        cfg_quiet_fix = qfix; quiet_allow = allow;
        tsf_now = 32'h0ABC_DE00 + TW'(q * 32'h0001_1000);
        e.res = eres; e.warn = ewarn; e.quiet = equiet; e.tag = tag;
        sb.push_back(e);
        d0 = n_done;
        stop_req = 1'b1;
        stop_qid = QW'(q);
        @(negedge clk);
        stop_req = 1'b0;
        if (eres == R_INV) begin
            chk(!busy && q_txd == '0 && q_early_term == '0, "R2 nothing touched",
                {busy, q_txd, q_early_term}, 0);
            @(negedge clk);
            chk(!busy && q_txd == '0 && q_early_term == '0, "R2 still idle",
                {busy, q_txd, q_early_term}, 0);
        end else begin
            chk(busy, "R3 busy", busy, 1);
            chk(q_early_term == (NQ'(1) << q), "R3 early first", q_early_term, NQ'(1) << q);
            chk(q_txd == '0, "R3 disable after early", q_txd, 0);
            @(negedge clk);
            chk(q_txd == (NQ'(1) << q), "R3 disable bit", q_txd, NQ'(1) << q);
            if (poke) begin
                @(negedge clk);
                stop_req = 1'b1;
                stop_qid = (q == 0) ? QW'(2) : QW'(0);
                @(negedge clk);
                stop_req = 1'b0;
                chk(q_txd == (NQ'(1) << q), "R12 target kept", q_txd, NQ'(1) << q);
            end
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (12) @(negedge clk);
        chk(n_done == d0 + 1, {tag, " R12 single done"}, n_done, d0 + 1);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 60000) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(!busy && !done && !ena_warn && !quiet_en && !chan_idle_force, "R1 reset flags",
            {busy, done, ena_warn, quiet_en, chan_idle_force}, 0);
        chk(q_txd == '0 && q_early_term == '0, "R1 reset controls", {q_txd, q_early_term}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && q_txd == '0, "R1 after release", {busy, done, q_txd}, 0);

        run_stop(1, 2, 4, 0, 0, R_INV, 0, 0, 0, "R2 inactive");
        run_stop(0, 2, 8, 0, 0, R_OK, 0, 0, 0, "R6 quick drain");
        run_stop(2, -1, 3, 0, 0, R_OK, 1, 0, 0, "R5 stop timeout");
        run_stop(7, 2, 4, 0, 0, R_INV, 1, 0, 0, "R2 out of range");
        run_stop(5, 5, 20, 0, 0, R_OK, 0, 0, 0, "R4 late drain");
        run_stop(3, 2, -1, 1, 1, R_OK, 0, 1, 0, "R7 quiet rescue");
        run_stop(4, 2, -1, 0, 1, R_BSY, 0, 1, 0, "R8 quiet no help");
        run_stop(0, 2, -1, 0, 0, R_BSY, 0, 0, 0, "R11 no fallback");
        run_stop(2, 3, 10, 0, 0, R_OK, 0, 0, 1, "R12 request ignored");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule